// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Scheduler

This block brings an SDRAM out of power-up and then keeps its rows refreshed for as long as the chip runs. After reset it stays silent for a programmed pause. It then requests a precharge of all banks, two auto-refresh cycles and a mode-register load. Each command is followed by the wait that the device needs before the next one. When the mode-load wait has elapsed it raises `init_done`, and from then on the main memory controller may run traffic.

In normal operation an interval timer expires once every refresh slot. The slot length is the 64 ms retention window divided by the row count, and `rows_8k` selects 4096 or 8192 rows. Each expiry adds one refresh to a debt counter, and `refresh_req` stays high while the debt is non-zero. A refresh is issued only on a cycle where the controller reports itself idle. Refreshes that were put off are paid back one per tRFC once the controller becomes idle again. If the debt would grow past its allowed limit, the retention guarantee is treated as broken. The block then reruns the wake-up: a precharge-all and two refreshes, with no mode reload.

All delays are parameters in nanoseconds or clocks and are turned into clock counts from a clock period in picoseconds. Commands are single-cycle pulses from registers.

Top module: `sdr_init_refresh_sched`

## Requirements
- R1: While reset is held, every output is 0. After reset is released, no command pulse appears until clock edge P+1, where P = ceil(PAUSE_NS/clock period). At that edge the first command, a precharge-all, is issued.
- R2: The first auto-refresh follows the precharge-all by exactly ceil(TRP_NS/period) edges. The second auto-refresh follows the first by exactly TRFC = ceil(TRFC_NS/period) edges. The mode-register load follows the second refresh by TRFC edges. `ctrl_idle` has no effect on this start-up sequence.
- R3: `init_done` rises exactly TMRD_CLK edges after the mode-register load. It is 0 before that, and it never falls except through reset. The mode-register load is issued once per reset, and never while `init_done` is high.
- R4: Each command output is a one-cycle pulse, and at most one of the three is high in any cycle.
- R5: The refresh interval is floor(WINDOW_NS·1000 / (rows·period_ps)) clocks. rows is 4096 when `rows_8k`=0 and 8192 when `rows_8k`=1. `refresh_req` first rises exactly one interval after `init_done` rises. Later expiries follow every interval, regardless of refresh issue.
- R6: With `ctrl_idle` high, a pending refresh is issued on the edge after `refresh_req` rises. `refresh_req` falls on that same edge when no further refresh is owed.
- R7: While `ctrl_idle` is low in normal operation, no auto-refresh is issued and each expiry adds one owed refresh, up to MAX_OWED. When `ctrl_idle` returns high, the owed refreshes are issued TRFC edges apart, and `refresh_req` falls with the last one.
- R8: An expiry that arrives while MAX_OWED refreshes are already owed starts a wake-up. `refresh_req` stays high and `init_done` stays high. Once `ctrl_idle` is high, a precharge-all is issued, then an auto-refresh TRP edges later and a second one TRFC edges after that. No mode-register load is issued. The debt restarts at zero.
- R9: No command is issued less than TRFC edges after an auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows_8k | input | 1 | Row count select: 0 = 4096 rows, 1 = 8192 rows |
| ctrl_idle | input | 1 | Main controller has all banks idle and yields the command bus |
| cmd_precharge_all | output | 1 | One-cycle request for a precharge of all banks |
| cmd_auto_refresh | output | 1 | One-cycle request for an auto-refresh |
| cmd_load_mode | output | 1 | One-cycle request for a mode-register load |
| init_done | output | 1 | Start-up sequence complete; normal traffic allowed |
| refresh_req | output | 1 | Refresh owed or wake-up in progress; controller should go idle |

## Verification
A wait counter loaded with the wrong value or a mis-decoded state moves a start-up command by one or more edges. The exact-edge comparison catches this at the first command after the fault, at most a few dozen clocks after reset. A wrong interval reload or selection shifts the first `refresh_req` rise, which is visible one interval after `init_done`. Debt-counter errors appear as a missing or extra refresh pulse during the paced drain after an idle gap, or as a wake-up that fires one interval early or late. A wake-up that wrongly re-enters start-up shows up at once as a second mode-register load or a dropped `init_done`.

// File: rtl/sdr_sched_pkg.sv
`timescale 1ns/1ps
package sdr_sched_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_INIT_TRP,
        ST_INIT_RFC1,
        ST_INIT_RFC2,
        ST_MRD,
        ST_RUN,
        ST_RUN_RFC,
        ST_WAKE_HOLD,
        ST_WAKE_TRP,
        ST_WAKE_RFC1
    } sched_state_e;

    // Round a delay up to whole clocks, never below one.
    function automatic int ns_to_clk(input longint ns, input longint clk_ps);
        longint c;
        c = (ns * 64'sd1000 + clk_ps - 64'sd1) / clk_ps;
        if (c < 64'sd1) c = 64'sd1;
        return int'(c);
    endfunction

    // Slot length in clocks: retention window split over all rows, rounded down.
    function automatic int slot_clk(input longint window_ns, input longint rows,
                                    input longint clk_ps);
        longint c;
        c = (window_ns * 64'sd1000) / (rows * clk_ps);
        if (c < 64'sd2) c = 64'sd2;
        return int'(c);
    endfunction

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sdr_refresh_interval.sv
`timescale 1ns/1ps
module sdr_refresh_interval
    import sdr_sched_pkg::*;
#(
    parameter int SLOT_SMALL = 40,
    parameter int SLOT_LARGE = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_large,
    output logic tick
);
    localparam int SLOT_MAX = (SLOT_SMALL > SLOT_LARGE) ? SLOT_SMALL : SLOT_LARGE;
    localparam int CNT_W    = bits_for(SLOT_MAX);
    localparam logic [CNT_W-1:0] LD_SMALL = CNT_W'(SLOT_SMALL - 1);
    localparam logic [CNT_W-1:0] LD_LARGE = CNT_W'(SLOT_LARGE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slot_regs_t;

    slot_regs_t q, d;
    logic [CNT_W-1:0] reload;

    always_comb begin
        d      = q;
        reload = sel_large ? LD_LARGE : LD_SMALL;
        tick   = 1'b0;
        if (!en) begin
            d.cnt = reload;
        end else if (q.cnt == '0) begin
            tick  = 1'b1;
            d.cnt = reload;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= LD_SMALL;
        end else begin
            q <= d;
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(SLOT_MAX - 1)); // R5
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5

endmodule

// File: rtl/sdr_refresh_debt.sv
`timescale 1ns/1ps
module sdr_refresh_debt
    import sdr_sched_pkg::*;
#(
    parameter int MAX_OWED = 8,
    localparam int OWED_W  = bits_for(MAX_OWED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              take,
    input  logic              arm,
    output logic [OWED_W-1:0] owed,
    output logic              overflow
);
    localparam logic [OWED_W-1:0] OWED_TOP = OWED_W'(MAX_OWED);

    typedef struct packed {
        logic [OWED_W-1:0] owed;
    } debt_regs_t;

    debt_regs_t q, d;

    always_comb begin
        d        = q;
        overflow = arm && tick && !take && (q.owed == OWED_TOP);
        if (overflow) begin
            d.owed = '0;
        end else begin
            unique case ({tick, take})
                2'b10: if (q.owed != OWED_TOP) d.owed = q.owed + 1'b1;
                2'b01: d.owed = q.owed - 1'b1;
                default: d.owed = q.owed;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.owed <= '0;
        end else begin
            q <= d;
        end
    end

    assign owed = q.owed;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.owed <= OWED_TOP); // R7
    AST_TAKE_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (q.owed != '0)); // R6
    AST_OVERFLOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (q.owed == '0)); // R8

endmodule

// File: rtl/sdr_init_refresh_sched.sv
`timescale 1ns/1ps
module sdr_init_refresh_sched
    import sdr_sched_pkg::*;
#(
    parameter int CLK_PS     = 10000,
    parameter int PAUSE_NS   = 100000,
    parameter int WINDOW_NS  = 64000000,
    parameter int ROWS_SMALL = 4096,
    parameter int ROWS_LARGE = 8192,
    parameter int TRP_NS     = 20,
    parameter int TRFC_NS    = 66,
    parameter int TMRD_CLK   = 2,
    parameter int MAX_OWED   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rows_8k,
    input  logic ctrl_idle,
    output logic cmd_precharge_all,
    output logic cmd_auto_refresh,
    output logic cmd_load_mode,
    output logic init_done,
    output logic refresh_req
);
    localparam int PAUSE_CLK  = ns_to_clk(longint'(PAUSE_NS), longint'(CLK_PS));
    localparam int TRP_CLK    = ns_to_clk(longint'(TRP_NS), longint'(CLK_PS));
    localparam int TRFC_CLK   = ns_to_clk(longint'(TRFC_NS), longint'(CLK_PS));
    localparam int MRD_CLK    = (TMRD_CLK < 1) ? 1 : TMRD_CLK;
    localparam int SLOT_SMALL = slot_clk(longint'(WINDOW_NS), longint'(ROWS_SMALL), longint'(CLK_PS));
    localparam int SLOT_LARGE = slot_clk(longint'(WINDOW_NS), longint'(ROWS_LARGE), longint'(CLK_PS));
    localparam int WAIT_A     = (PAUSE_CLK > TRP_CLK) ? PAUSE_CLK : TRP_CLK;
    localparam int WAIT_B     = (TRFC_CLK > MRD_CLK) ? TRFC_CLK : MRD_CLK;
    localparam int WAIT_MAX   = (WAIT_A > WAIT_B) ? WAIT_A : WAIT_B;
    localparam int WAIT_W     = bits_for(WAIT_MAX);
    localparam int OWED_W     = bits_for(MAX_OWED);
    localparam int GAP_W      = bits_for(TRFC_CLK);

    localparam logic [WAIT_W-1:0] LD_PAUSE = WAIT_W'(PAUSE_CLK);
    localparam logic [WAIT_W-1:0] LD_TRP   = WAIT_W'(TRP_CLK - 1);
    localparam logic [WAIT_W-1:0] LD_TRFC  = WAIT_W'(TRFC_CLK - 1);
    localparam logic [WAIT_W-1:0] LD_MRD   = WAIT_W'(MRD_CLK - 1);

    typedef struct packed {
        sched_state_e      state;
        logic [WAIT_W-1:0] wcnt;
        logic              done;
        logic              pre;
        logic              aref;
        logic              lmr;
    } sched_regs_t;

    sched_regs_t q, d;

    logic              slot_tick;
    logic [OWED_W-1:0] owed;
    logic              overflow;
    logic              wait_over;
    logic              run_step;
    logic              take;
    logic              arm;
    logic              in_wake;

    sdr_refresh_interval #(
        .SLOT_SMALL (SLOT_SMALL),
        .SLOT_LARGE (SLOT_LARGE)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (q.done),
        .sel_large (rows_8k),
        .tick      (slot_tick)
    );

    sdr_refresh_debt #(
        .MAX_OWED (MAX_OWED)
    ) u_debt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slot_tick),
        .take     (take),
        .arm      (arm),
        .owed     (owed),
        .overflow (overflow)
    );

    always_comb begin
        wait_over = (q.wcnt == '0);
        run_step  = (q.state == ST_RUN) || ((q.state == ST_RUN_RFC) && wait_over);
        take      = run_step && ctrl_idle && (owed != '0);
        arm       = (q.state == ST_RUN) || (q.state == ST_RUN_RFC);
        in_wake   = (q.state == ST_WAKE_HOLD) || (q.state == ST_WAKE_TRP)
                 || (q.state == ST_WAKE_RFC1);
    end

    always_comb begin
        d      = q;
        d.pre  = 1'b0;
        d.aref = 1'b0;
        d.lmr  = 1'b0;
        if (!wait_over) d.wcnt = q.wcnt - 1'b1;
        unique case (q.state)
            ST_PAUSE: begin
                if (wait_over) begin
                    d.pre   = 1'b1;
                    d.wcnt  = LD_TRP;
                    d.state = ST_INIT_TRP;
                end
            end
            ST_INIT_TRP: begin
                if (wait_over) begin
                    d.aref  = 1'b1;
                    d.wcnt  = LD_TRFC;
                    d.state = ST_INIT_RFC1;
                end
            end
            ST_INIT_RFC1: begin
                if (wait_over) begin
                    d.aref  = 1'b1;
                    d.wcnt  = LD_TRFC;
                    d.state = ST_INIT_RFC2;
                end
            end
            ST_INIT_RFC2: begin
                if (wait_over) begin
                    d.lmr   = 1'b1;
                    d.wcnt  = LD_MRD;
                    d.state = ST_MRD;
                end
            end
            ST_MRD: begin
                if (wait_over) begin
                    d.done  = 1'b1;
                    d.state = ST_RUN;
                end
            end
            ST_RUN, ST_RUN_RFC: begin
                if (overflow) begin
                    d.state = ST_WAKE_HOLD;
                end else if (take) begin
                    d.aref  = 1'b1;
                    d.wcnt  = LD_TRFC;
                    d.state = ST_RUN_RFC;
                end else if (run_step) begin
                    d.state = ST_RUN;
                end
            end
            ST_WAKE_HOLD: begin
                if (wait_over && ctrl_idle) begin
                    d.pre   = 1'b1;
                    d.wcnt  = LD_TRP;
                    d.state = ST_WAKE_TRP;
                end
            end
            ST_WAKE_TRP: begin
                if (wait_over) begin
                    d.aref  = 1'b1;
                    d.wcnt  = LD_TRFC;
                    d.state = ST_WAKE_RFC1;
                end
            end
            ST_WAKE_RFC1: begin
                if (wait_over) begin
                    d.aref  = 1'b1;
                    d.wcnt  = LD_TRFC;
                    d.state = ST_RUN_RFC;
                end
            end
            default: d.state = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_PAUSE;
            q.wcnt  <= LD_PAUSE;
            q.done  <= 1'b0;
            q.pre   <= 1'b0;
            q.aref  <= 1'b0;
            q.lmr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_precharge_all = q.pre;
    assign cmd_auto_refresh  = q.aref;
    assign cmd_load_mode     = q.lmr;
    assign init_done         = q.done;
    assign refresh_req       = (owed != '0) || in_wake;

    // Clocks elapsed since the last refresh pulse, saturating at tRFC.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(TRFC_CLK);
        end else if (cmd_auto_refresh) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != GAP_W'(TRFC_CLK)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PAUSE) |-> !(cmd_precharge_all || cmd_auto_refresh || cmd_load_mode)); // R1
    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_precharge_all, cmd_auto_refresh, cmd_load_mode})); // R4
    AST_PRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_precharge_all |=> !cmd_precharge_all); // R4
    AST_LMR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load_mode |=> !cmd_load_mode); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done)); // R3
    AST_LMR_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load_mode |-> !init_done); // R3
    AST_RUN_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_auto_refresh && (q.state == ST_RUN_RFC) && ($past(q.state) != ST_WAKE_RFC1))
            |-> $past(ctrl_idle)); // R6
    AST_WAKE_NO_LMR: assert property (@(posedge clk) disable iff (!rst_n)
        in_wake |-> (!cmd_load_mode && init_done && refresh_req)); // R8
    AST_TRFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_auto_refresh || cmd_precharge_all || cmd_load_mode)
            |-> (gap_q >= GAP_W'(TRFC_CLK))); // R9

endmodule

// File: tb/tb_sdr_init_refresh_sched.sv
`timescale 1ns/1ps
module tb_sdr_init_refresh_sched;

    localparam int CLK_PS    = 20000;
    localparam int PAUSE_NS  = 400;
    localparam int WINDOW_NS = 3276800;
    localparam int TRP_NS    = 30;
    localparam int TRFC_NS   = 70;
    localparam int TMRD      = 2;
    localparam int MAXO      = 3;

    // Expected values from the requirements.
    localparam int XP    = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int XTRP  = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int XTRFC = (TRFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int INT4  = (WINDOW_NS / 4096) * 1000 / CLK_PS;
    localparam int INT8  = (WINDOW_NS / 8192) * 1000 / CLK_PS;
    localparam int E_PRE  = XP + 1;
    localparam int E_R1   = E_PRE + XTRP;
    localparam int E_R2   = E_R1 + XTRFC;
    localparam int E_LMR  = E_R2 + XTRFC;
    localparam int E_DONE = E_LMR + TMRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rows_8k = 1'b0;
    logic ctrl_idle = 1'b0;
    logic cmd_precharge_all, cmd_auto_refresh, cmd_load_mode, init_done, refresh_req;

    sdr_init_refresh_sched #(
        .CLK_PS    (CLK_PS),
        .PAUSE_NS  (PAUSE_NS),
        .WINDOW_NS (WINDOW_NS),
        .TRP_NS    (TRP_NS),
        .TRFC_NS   (TRFC_NS),
        .TMRD_CLK  (TMRD),
        .MAX_OWED  (MAXO)
    ) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .rows_8k           (rows_8k),
        .ctrl_idle         (ctrl_idle),
        .cmd_precharge_all (cmd_precharge_all),
        .cmd_auto_refresh  (cmd_auto_refresh),
        .cmd_load_mode     (cmd_load_mode),
        .init_done         (init_done),
        .refresh_req       (refresh_req)
    );

    always #10 clk = ~clk;

    int cyc;
    int tests = 0;
    int fails = 0;
    int ev_kind [0:31];
    int ev_cyc  [0:31];
    int n_ev;
    int done_rise, req_rise1;
    int multi_viol = 0;
    int pulse_viol = 0;
    logic done_prev, req_prev, pre_prev, ref_prev, lmr_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_precharge_all && n_ev < 32) begin ev_kind[n_ev] = 1; ev_cyc[n_ev] = cyc; n_ev++; end
            if (cmd_auto_refresh  && n_ev < 32) begin ev_kind[n_ev] = 2; ev_cyc[n_ev] = cyc; n_ev++; end
            if (cmd_load_mode     && n_ev < 32) begin ev_kind[n_ev] = 3; ev_cyc[n_ev] = cyc; n_ev++; end
            if ((int'(cmd_precharge_all) + int'(cmd_auto_refresh) + int'(cmd_load_mode)) > 1)
                multi_viol++;
            if ((cmd_precharge_all && pre_prev) || (cmd_auto_refresh && ref_prev)
                || (cmd_load_mode && lmr_prev))
                pulse_viol++;
            if (init_done && !done_prev && done_rise < 0) done_rise = cyc;
            if (refresh_req && !req_prev && req_rise1 < 0) req_rise1 = cyc;
            done_prev = init_done;
            req_prev  = refresh_req;
            pre_prev  = cmd_precharge_all;
            ref_prev  = cmd_auto_refresh;
            lmr_prev  = cmd_load_mode;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int idx, input int kind, input int c, input string tag);
        int ak, ac;
        ak = (idx < n_ev) ? ev_kind[idx] : -1;
        ac = (idx < n_ev) ? ev_cyc[idx] : -1;
        chk(ak == kind && ac == c, tag, $sformatf("event %0d kind %0d cycle", idx, kind), ac, c);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic start(input logic big, input logic idle);
        @(negedge clk);
        rst_n = 1'b0;
        rows_8k = big;
        ctrl_idle = idle;
        repeat (3) @(negedge clk);
        chk({cmd_precharge_all, cmd_auto_refresh, cmd_load_mode, init_done, refresh_req} == 5'b0,
            "R1", "outputs in reset",
            int'({cmd_precharge_all, cmd_auto_refresh, cmd_load_mode, init_done, refresh_req}), 0);
        n_ev = 0; done_rise = -1; req_rise1 = -1;
        done_prev = 1'b0; req_prev = 1'b0; pre_prev = 1'b0; ref_prev = 1'b0; lmr_prev = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic check_init();
        expect_ev(0, 1, E_PRE, "R1");
        expect_ev(1, 2, E_R1, "R2");
        expect_ev(2, 2, E_R2, "R2");
        expect_ev(3, 3, E_LMR, "R2");
        chk(done_rise == E_DONE, "R3", "init_done rise cycle", done_rise, E_DONE);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rb, ov;
        // Sweep both row counts with the controller always idle.
        for (int big = 0; big < 2; big++) begin
            int iv;
            iv = (big != 0) ? INT8 : INT4;
            start(big[0], 1'b1);
            wait_until(E_DONE - 1);
            chk(init_done == 1'b0, "R3", "init_done before wait", int'(init_done), 0);
            wait_until(E_DONE + 3 * iv + 5);
            check_init();
            chk(req_rise1 == E_DONE + iv, "R5", "first refresh_req rise", req_rise1, E_DONE + iv);
            for (int k = 1; k <= 3; k++)
                expect_ev(3 + k, 2, E_DONE + k * iv + 1, "R6");
            chk(n_ev == 7, "R5", "command count", n_ev, 7);
        end

        // Controller busy for two slots, then drains the debt (R7, R9).
        start(1'b1, 1'b0);
        rb = E_DONE + 2 * INT8 + 7;
        wait_until(rb);
        check_init();
        chk(n_ev == 4, "R7", "refreshes while busy", n_ev, 4);
        chk(refresh_req == 1'b1, "R7", "refresh_req while owed", int'(refresh_req), 1);
        ctrl_idle = 1'b1;
        wait_until(rb + 1 + XTRFC + 1);
        chk(refresh_req == 1'b0, "R7", "refresh_req after drain", int'(refresh_req), 0);
        wait_until(E_DONE + 3 * INT8 + 6);
        expect_ev(4, 2, rb + 1, "R7");
        expect_ev(5, 2, rb + 1 + XTRFC, "R9");
        expect_ev(6, 2, E_DONE + 3 * INT8 + 1, "R5");
        chk(n_ev == 7, "R7", "command count after drain", n_ev, 7);

        // Debt exceeds its limit: wake-up sequence (R8).
        start(1'b1, 1'b0);
        ov = E_DONE + (MAXO + 1) * INT8;
        wait_until(ov + 3);
        chk(n_ev == 4, "R8", "no command before idle", n_ev, 4);
        chk(refresh_req == 1'b1, "R8", "refresh_req during wake-up", int'(refresh_req), 1);
        chk(init_done == 1'b1, "R8", "init_done during wake-up", int'(init_done), 1);
        ctrl_idle = 1'b1;
        wait_until(ov + 4 + XTRP + XTRFC + 1);
        chk(refresh_req == 1'b0, "R8", "refresh_req after wake-up", int'(refresh_req), 0);
        chk(init_done == 1'b1, "R3", "init_done kept", int'(init_done), 1);
        wait_until(E_DONE + 5 * INT8 + 5);
        expect_ev(4, 1, ov + 4, "R8");
        expect_ev(5, 2, ov + 4 + XTRP, "R8");
        expect_ev(6, 2, ov + 4 + XTRP + XTRFC, "R8");
        expect_ev(7, 2, E_DONE + 5 * INT8 + 1, "R8");
        chk(n_ev == 8, "R8", "no second mode load", n_ev, 8);

        // Reset while running clears everything.
        start(1'b0, 1'b1);
        chk(multi_viol == 0, "R4", "cycles with several commands", multi_viol, 0);
        chk(pulse_viol == 0, "R4", "commands longer than a cycle", pulse_viol, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule